// File: doc/BRIEF.md
# Self-Clocked Conversion Result Serializer

This block is the digital output stage of a converter that produces its own serial clock. It runs a fixed loop: a timed conversion, a short sleep, then an output frame. It drives a serial clock, a data line and a busy flag itself, so the receiver needs only two inputs. The conversion time, the sleep time and the serial clock half-period are all counted in system clock cycles. A 32-bit result word is taken from a parallel input when the conversion ends and is shifted out most significant bit first.

A chip-select input lets the host end an output frame early. This suits a host that needs only the upper bits, wants to discard a result, or wants to re-time the next conversion. An oversampling ratio code is taken from a parallel input at the end of each conversion and applies to the following conversion. If the host cuts a frame short before enough clock edges have passed, the following conversion gets a partly formed code instead. The code in force is shown on an output so the host can see it.

Top module: `selfclk_serializer`

## Requirements
- R1: While a conversion runs, `busy_o`, `sck_o` and `sdo_o` are all 1. A conversion lasts exactly CONV_CYCLES cycles, both after reset and after each frame.
- R2: In the cycle a conversion ends, `busy_o`, `sck_o` and `sdo_o` all drop to 0 together.
- R3: Without any input, `sck_o` stays low for SLEEP_CYCLES sleep cycles plus one HALF_CYCLES half-period, and then makes its first rising edge.
- R4: During a frame `sck_o` has a period of 2*HALF_CYCLES cycles. An uninterrupted frame has exactly 32 rising edges.
- R5: The value on `sdo_o` just before rising edge k (k = 1..32) is bit 32-k of the result word, so bit 31 comes first. `sdo_o` changes only while `sck_o` is low. The word is the value of `result_i` in the last conversion cycle, and later changes to `result_i` have no effect on the frame.
- R6: At the 32nd rising edge, `busy_o` and `sdo_o` go to 1, `sck_o` stays 1, and a new conversion starts.
- R7: A rising edge on `cs_i` after the first and before the 32nd `sck_o` rising edge ends the frame. In the next cycle all three outputs are 1 and a full-length conversion is running.
- R8: A rising edge on `cs_i` during conversion, during sleep, or before the first `sck_o` rising edge is ignored. The frame then completes all 32 edges.
- R9: `ratio_i` is sampled in the last conversion cycle. After a complete frame, or after an abort that follows at least RATIO_W (5) rising edges, that code appears on `ratio_act_o` when the next conversion starts. `ratio_act_o` does not change during a conversion.
- R10: After an abort that follows n < RATIO_W rising edges, `ratio_act_o` keeps the top n bits of the sampled code (bit RATIO_W-1 is the top bit) and sets the remaining bits to 0. The next complete frame restores the full sampled code.
- R11: During and right after reset, the block is in conversion with all three outputs at 1 and `ratio_act_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| result_i | input | 32 | Result word, captured at the end of each conversion |
| ratio_i | input | RATIO_W | Ratio code for the next conversion |
| cs_i | input | 1 | Chip select; a rising edge aborts the frame |
| sck_o | output | 1 | Serial clock generated by the block |
| sdo_o | output | 1 | Serial data; the end-of-conversion flag outside a frame |
| busy_o | output | 1 | High while a conversion runs |
| ratio_act_o | output | RATIO_W | Ratio code used by the current conversion |

## Verification
The bench aborts a frame after every possible edge count from 1 to 31 and follows each abort with a complete frame. Abort counts below five check the truncated ratio code, and the complete frames check that the full code returns. A design that counted the edge in progress, or that missed the edge that starts a half-period, would give a code with one bit too many or too few. A design that never restored the code would keep the truncated value. The bench also sends chip-select pulses during sleep and just before the first clock edge; a design that acted on these would end the frame early. It changes `result_i` and `ratio_i` as soon as a conversion ends, so a design that sampled them late would shift out the wrong word or report the wrong code.

// File: rtl/ssz_pkg.sv
// Shared types and constants for the self-clocked serializer.
// Assumes one frame always carries a 32-bit word.
package ssz_pkg;
    typedef enum logic [1:0] {
        PH_CONV  = 2'd0,
        PH_SLEEP = 2'd1,
        PH_OUT   = 2'd2
    } ssz_phase_e;

    localparam int unsigned SSZ_FRAME_BITS = 32;
    localparam int unsigned SSZ_EDGE_W     = $clog2(SSZ_FRAME_BITS + 1);
endpackage

// File: rtl/ssz_phase_seq.sv
// Phase sequencer: conversion -> sleep -> output -> conversion.
// Conversion and sleep run for a set number of cycles. The output phase ends
// on frame completion or on an abort. Assumes both cycle counts are >= 1.
module ssz_phase_seq
    import ssz_pkg::*;
#(
    parameter int unsigned CONV_CYCLES  = 20,
    parameter int unsigned SLEEP_CYCLES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_done_i,
    input  logic       abort_i,
    output ssz_phase_e phase_o,
    output logic       conv_end_o
);
    localparam int unsigned TMR_MAX = (CONV_CYCLES > SLEEP_CYCLES) ? CONV_CYCLES : SLEEP_CYCLES;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    logic [TMR_W-1:0] tmr_q;
    logic             sleep_end;

    // Last cycle of each timed phase
    assign conv_end_o = (phase_o == PH_CONV)  && (tmr_q == TMR_W'(CONV_CYCLES - 1));
    assign sleep_end  = (phase_o == PH_SLEEP) && (tmr_q == TMR_W'(SLEEP_CYCLES - 1));

    // Phase register and shared phase timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= PH_CONV;
            tmr_q   <= '0;
        end else begin
            case (phase_o)
                PH_CONV: begin
                    if (conv_end_o) begin
                        phase_o <= PH_SLEEP;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PH_SLEEP: begin
                    if (sleep_end) begin
                        phase_o <= PH_OUT;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    tmr_q <= '0;
                    if (frame_done_i || abort_i) begin
                        phase_o <= PH_CONV;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ssz_sck_gen.sv
// Serial clock generator. Outside the output phase the clock register is
// held low and the edge counter is cleared. Inside it, the clock toggles
// every HALF_CYCLES cycles, starting low, and rising edges are counted.
// Assumes HALF_CYCLES >= 1.
module ssz_sck_gen
    import ssz_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ssz_phase_e            phase_i,
    output logic                  sck_o,
    output logic                  rise_ev_o,
    output logic                  fall_ev_o,
    output logic [SSZ_EDGE_W-1:0] rise_cnt_o
);
    localparam int unsigned HC_W = $clog2(HALF_CYCLES + 1);

    logic [HC_W-1:0] hc_q;
    logic            toggle;

    // A half-period ends in this cycle
    assign toggle    = (phase_i == PH_OUT) && (hc_q == HC_W'(HALF_CYCLES - 1));
    assign rise_ev_o = toggle && !sck_o;
    assign fall_ev_o = toggle && sck_o;

    // Half-period divider, clock level and rising-edge count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q       <= '0;
            sck_o      <= 1'b0;
            rise_cnt_o <= '0;
        end else if (phase_i != PH_OUT) begin
            hc_q       <= '0;
            sck_o      <= 1'b0;
            rise_cnt_o <= '0;
        end else if (toggle) begin
            hc_q  <= '0;
            sck_o <= !sck_o;
            if (!sck_o) begin
                rise_cnt_o <= rise_cnt_o + 1'b1;
            end
        end else begin
            hc_q <= hc_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssz_shifter.sv
// Output shift register: loads the word at conversion end and shifts left
// on each falling serial clock edge. The top bit is the serial data.
module ssz_shifter #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              msb_o
);
    logic [WORD_W-1:0] sh_q;

    assign msb_o = sh_q[WORD_W-1];

    // Capture on load, shift on falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= word_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/ssz_ratio_sel.sv
// Ratio selection: samples the requested code at conversion end. When the
// output phase ends, it applies that code, or a top-bits-only version of it
// if the abort came before KEEP_EDGES rising edges.
module ssz_ratio_sel
    import ssz_pkg::*;
#(
    parameter int unsigned RATIO_W    = 5,
    parameter int unsigned KEEP_EDGES = RATIO_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_i,
    input  logic [RATIO_W-1:0]    ratio_i,
    input  logic                  full_i,
    input  logic                  abort_i,
    input  logic [SSZ_EDGE_W-1:0] edges_i,
    output logic [RATIO_W-1:0]    ratio_act_o
);
    logic [RATIO_W-1:0] prog_q;
    logic [RATIO_W-1:0] keep_mask;
    logic [RATIO_W-1:0] abort_code;

    // Keep the top `edges_i` bits of the code
    always_comb begin
        for (int i = 0; i < RATIO_W; i++) begin
            keep_mask[RATIO_W-1-i] = (int'(edges_i) > i);
        end
        abort_code = (int'(edges_i) >= KEEP_EDGES) ? prog_q : (prog_q & keep_mask);
    end

    // Programmed code and code in force
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q      <= '0;
            ratio_act_o <= '0;
        end else begin
            if (sample_i) begin
                prog_q <= ratio_i;
            end
            if (full_i) begin
                ratio_act_o <= prog_q;
            end else if (abort_i) begin
                ratio_act_o <= abort_code;
            end
        end
    end
endmodule

// File: rtl/selfclk_serializer.sv
// Top of the self-clocked serializer. Connects the phase sequencer, clock
// generator, shifter and ratio selector, detects the chip-select edge that
// aborts a frame, and drives the output lines from the phase.
// Assumes cs_i is synchronous to clk.
module selfclk_serializer
    import ssz_pkg::*;
#(
    parameter int unsigned CONV_CYCLES  = 20,
    parameter int unsigned SLEEP_CYCLES = 5,
    parameter int unsigned HALF_CYCLES  = 2,
    parameter int unsigned RATIO_W      = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SSZ_FRAME_BITS-1:0] result_i,
    input  logic [RATIO_W-1:0]        ratio_i,
    input  logic                      cs_i,
    output logic                      sck_o,
    output logic                      sdo_o,
    output logic                      busy_o,
    output logic [RATIO_W-1:0]        ratio_act_o
);
    ssz_phase_e            phase;
    logic                  conv_end;
    logic                  sck_int;
    logic                  rise_ev;
    logic                  fall_ev;
    logic [SSZ_EDGE_W-1:0] rise_cnt;
    logic                  frame_done;
    logic                  abort;
    logic                  cs_q;
    logic                  data_bit;

    // Chip-select history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
        end else begin
            cs_q <= cs_i;
        end
    end

    // Frame end and accepted abort
    assign frame_done = rise_ev && (rise_cnt == SSZ_EDGE_W'(SSZ_FRAME_BITS - 1));
    assign abort      = (phase == PH_OUT) && cs_i && !cs_q
                        && (rise_cnt != '0) && !frame_done;

    ssz_phase_seq #(
        .CONV_CYCLES (CONV_CYCLES),
        .SLEEP_CYCLES(SLEEP_CYCLES)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done_i(frame_done),
        .abort_i     (abort),
        .phase_o     (phase),
        .conv_end_o  (conv_end)
    );

    ssz_sck_gen #(
        .HALF_CYCLES(HALF_CYCLES)
    ) sck_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase),
        .sck_o     (sck_int),
        .rise_ev_o (rise_ev),
        .fall_ev_o (fall_ev),
        .rise_cnt_o(rise_cnt)
    );

    ssz_shifter #(
        .WORD_W(SSZ_FRAME_BITS)
    ) shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (conv_end),
        .word_i (result_i),
        .shift_i(fall_ev),
        .msb_o  (data_bit)
    );

    ssz_ratio_sel #(
        .RATIO_W   (RATIO_W),
        .KEEP_EDGES(RATIO_W)
    ) rat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (conv_end),
        .ratio_i    (ratio_i),
        .full_i     (frame_done),
        .abort_i    (abort),
        .edges_i    (rise_cnt),
        .ratio_act_o(ratio_act_o)
    );

    // Output lines by phase
    always_comb begin
        case (phase)
            PH_CONV: begin
                sck_o  = 1'b1;
                sdo_o  = 1'b1;
                busy_o = 1'b1;
            end
            PH_SLEEP: begin
                sck_o  = 1'b0;
                sdo_o  = 1'b0;
                busy_o = 1'b0;
            end
            default: begin
                sck_o  = sck_int;
                sdo_o  = data_bit;
                busy_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/selfclk_serializer_chk.sv
// Port-level checker for the self-clocked serializer, bound to the top.
// Assumes cs_i is synchronous to clk.
module selfclk_serializer_chk #(
    parameter int unsigned SLEEP_CYCLES = 5,
    parameter int unsigned RATIO_W      = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_i,
    input logic               sck_o,
    input logic               sdo_o,
    input logic               busy_o,
    input logic [RATIO_W-1:0] ratio_act_o
);
    logic [15:0] low_q;
    logic        seen_q;

    // Count low clock cycles since the conversion ended
    always_ff @(posedge clk) begin
        if (!rst_n || busy_o) begin
            low_q <= '0;
        end else if (!sck_o && low_q != 16'hFFFF) begin
            low_q <= low_q + 1'b1;
        end
    end

    // Remember that the frame has shown a high clock
    always_ff @(posedge clk) begin
        if (!rst_n || busy_o) begin
            seen_q <= 1'b0;
        end else if (sck_o) begin
            seen_q <= 1'b1;
        end
    end

    AST_CONV_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (sck_o && sdo_o)); // R1
    AST_END_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (!sck_o && !sdo_o)); // R2
    AST_SLEEP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sck_o) && !busy_o) |-> (low_q >= 16'(SLEEP_CYCLES))); // R3
    AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o) && sck_o && $past(sck_o)) |-> $stable(sdo_o)); // R5
    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && seen_q && cs_i && !$past(cs_i)) |=> busy_o); // R7
    AST_RATIO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ratio_act_o)); // R9
endmodule

bind selfclk_serializer selfclk_serializer_chk #(
    .SLEEP_CYCLES(SLEEP_CYCLES),
    .RATIO_W     (RATIO_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs_i),
    .sck_o      (sck_o),
    .sdo_o      (sdo_o),
    .busy_o     (busy_o),
    .ratio_act_o(ratio_act_o)
);

// File: tb/selfclk_serializer_tb_top.sv
`timescale 1ns/1ps
// Bench: aborts after every edge count 1..31, each followed by a full frame.
module selfclk_serializer_tb_top;
    localparam int CONV  = 20;
    localparam int SLEEP = 5;
    localparam int HALF  = 2;
    localparam int RW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   result_i = '0;
    logic [RW-1:0] ratio_i = '0;
    logic          cs_i = 1'b0;
    logic          sck_o, sdo_o, busy_o;
    logic [RW-1:0] ratio_act_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    selfclk_serializer #(
        .CONV_CYCLES (CONV),
        .SLEEP_CYCLES(SLEEP),
        .HALF_CYCLES (HALF),
        .RATIO_W     (RW)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .result_i   (result_i),
        .ratio_i    (ratio_i),
        .cs_i       (cs_i),
        .sck_o      (sck_o),
        .sdo_o      (sdo_o),
        .busy_o     (busy_o),
        .ratio_act_o(ratio_act_o)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // One conversion plus its frame; abort_n = 0 runs the full frame
    task automatic run_cycle(input logic [31:0] w, input logic [RW-1:0] r, input int abort_n, input bit early_cs);
        int cc = 0;
        int lc = 0;
        int k = 0;
        int cyc = 0;
        int last_rise = 0;
        bit done = 0;
        logic prev_s = 1'b0;
        logic prev_sdo = 1'b0;
        logic [RW-1:0] exp_r;
        result_i = w;
        ratio_i  = r;
        while (busy_o && cc < 10 * CONV) begin
            check(sck_o && sdo_o, "R1 lines high in conversion", {sck_o, sdo_o}, 3);
            cc++;
            @(negedge clk);
        end
        check(cc == CONV, "R1 conversion length", cc, CONV);
        check(!sck_o && !sdo_o && !busy_o, "R2 all low at conversion end", {busy_o, sck_o, sdo_o}, 0);
        result_i = ~w;   // R5: must not reach the frame
        ratio_i  = ~r;   // R9: sampled already
        while (!sck_o && !busy_o && lc < 1000) begin
            lc++;
            prev_sdo = sdo_o;
            cs_i = early_cs && (lc == 1 || lc == SLEEP + 1);  // R8 ignored pulses
            @(negedge clk);
        end
        cs_i = 1'b0;
        check(lc == SLEEP + HALF, "R3 low time before first rise", lc, SLEEP + HALF);
        while (!done) begin
            if (sck_o && !prev_s) begin
                k++;
                check(prev_sdo == w[32-k], "R5 data bit at rise", prev_sdo, w[32-k]);
                if (k > 1) check(cyc - last_rise == 2 * HALF, "R4 clock period", cyc - last_rise, 2 * HALF);
                last_rise = cyc;
                if (k == 32) begin
                    check(busy_o && sck_o && sdo_o, "R6 state after 32nd rise", {busy_o, sck_o, sdo_o}, 7);
                    done = 1;
                end else if (k == abort_n) begin
                    cs_i = 1'b1;
                    @(negedge clk);
                    cs_i = 1'b0;
                    check(busy_o && sck_o && sdo_o, "R7 abort starts conversion", {busy_o, sck_o, sdo_o}, 7);
                    done = 1;
                end
            end
            if (!done) begin
                if (busy_o) begin
                    check(0, "R4 R8 frame ended early", k, (abort_n == 0) ? 32 : abort_n);
                    done = 1;
                end else begin
                    prev_s = sck_o;
                    prev_sdo = sdo_o;
                    cyc++;
                    @(negedge clk);
                end
            end
        end
        exp_r = r;
        if (abort_n != 0 && abort_n < RW) begin
            for (int i = 0; i < RW; i++) if (i >= abort_n) exp_r[RW-1-i] = 1'b0;
        end
        if (abort_n == 0)
            check(ratio_act_o == exp_r, "R9 ratio after full frame", ratio_act_o, exp_r);
        else if (abort_n >= RW)
            check(ratio_act_o == exp_r, "R9 ratio after late abort", ratio_act_o, exp_r);
        else
            check(ratio_act_o == exp_r, "R10 truncated ratio after early abort", ratio_act_o, exp_r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o && sck_o && sdo_o, "R11 outputs in reset", {busy_o, sck_o, sdo_o}, 7);
        check(ratio_act_o == '0, "R11 ratio in reset", ratio_act_o, 0);
        rst_n = 1'b1;
        run_cycle(32'h8000_0001, 5'h1F, 0, 1'b0);
        for (int n = 1; n < 32; n++) begin
            logic [31:0] wa;
            logic [31:0] wb;
            wa = 32'hA5C3_0F96 ^ (32'(n) * 32'h0123_4567);
            wb = 32'h3C5A_E10B + (32'(n) * 32'h9E37_79B9);
            run_cycle(wa, RW'((n * 7 + 3) % 32), n, 1'b0);
            run_cycle(wb, RW'((n * 11 + 17) % 32), 0, (n % 3) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule